// File: doc/BRIEF.md
# Channel Command List Fetcher

This block walks a chain of two-word I/O command descriptors for one channel. The descriptors sit in a word-addressed memory that has a single synchronous read port. A start pulse delivers the byte address of the first descriptor. The block then reads word 1 of the descriptor and takes the command code from it. A transfer-in-channel (TIC) descriptor redirects the list to a new address. Any other code supplies the data buffer address, and the block then reads word 2 from the following word.

Every address the block is about to use is checked against the configured memory size. When an address falls outside memory, or a TIC appears where the chaining rules forbid one, the operation stops. The block then raises program check, channel end and interrupt pending together. When a descriptor completes cleanly, a next-request pulse continues the chain at the descriptor that follows it in memory.

Top module: `cmdlist_fetch`

## Requirements
- R1: After reset, `busy`, `cmd_valid`, `prog_check`, `chan_end` and `irq_pend` are all low.
- R2: Only the low 24 bits of `list_addr` and of descriptor word 1 are used as addresses. Bits 31..24 of `list_addr` have no effect.
- R3: Memory is read at word address = (24-bit byte address) >> 2. Read data is taken one cycle after `mem_rd_en`. In the cycle after a start pulse is sampled, `mem_rd_en` is high with the word address of the list.
- R4: For a non-TIC descriptor, `cmd_code` = word1[27:24], `data_addr` = word1[23:0], and `desc_w2` is the word at list byte address + 4. Bits 31..28 of word 1 are ignored. The result appears 4 cycles after the start pulse is sampled.
- R5: A TIC (code 4'h8) loads the list address from word1[23:0] and restarts the fetch there. Each TIC adds 2 cycles to the latency.
- R6: A TIC as the first descriptor after a start pulse causes program check. `busy` drops 2 cycles after the fetch of that word begins.
- R7: A TIC that directly follows another TIC causes program check.
- R8: An address at or above `MEM_BYTES` ends the operation with `prog_check`, `chan_end` and `irq_pend` all high and no `cmd_valid`. The address may be the word-1 list address, the data address or the word-2 address. `busy` drops 1, 2 or 3 cycles respectively after the fetch of that descriptor begins.
- R9: `busy` is high from the cycle after an accepted start until the result or error appears. `cmd_valid` is a single-cycle pulse in the first cycle that `busy` is low.
- R10: `next_req` after a clean descriptor fetches the descriptor at list byte address + 8. A TIC is allowed as that descriptor.
- R11: The status flags stay set until the next accepted start, which clears them.
- R12: `start` and `next_req` are ignored while `busy` is high. `next_req` is also ignored after an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new chain at `list_addr` |
| list_addr | input | 32 | Byte address of the first descriptor |
| next_req | input | 1 | Continue with the following descriptor |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 22 | Memory word address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the strobe |
| busy | output | 1 | Fetch in progress |
| cmd_valid | output | 1 | One-cycle pulse: a descriptor has been decoded |
| cmd_code | output | 4 | Command code of the decoded descriptor |
| data_addr | output | 24 | Data buffer byte address |
| desc_w2 | output | 32 | Descriptor word 2 |
| prog_check | output | 1 | Program check status |
| chan_end | output | 1 | Forced channel end |
| irq_pend | output | 1 | Interrupt pending |

## Verification
Each result has a fixed delay after the start or next-request edge:
- a clean descriptor completes after 4 cycles, plus 2 cycles for every TIC followed;
- a bad list address ends the operation after 1 cycle;
- a misplaced TIC or a bad data address ends it after 2 cycles;
- a bad word-2 address ends it after 3 cycles.

The driver works out the cycle at which `busy` should fall and queues it with the expected fields. The monitor checks the cycle count at the falling edge of `busy`, on the inactive clock edge, and compares every field in that same cycle.

// File: rtl/cmdlist_pkg.sv
package cmdlist_pkg;

    localparam int unsigned LA_W = 24;
    localparam int unsigned DW   = 32;
    localparam int unsigned WA_W = LA_W - 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD1,
        ST_W1,
        ST_RD2,
        ST_W2
    } fetch_st_e;

    typedef struct packed {
        logic [3:0]      code;
        logic            is_tic;
        logic [LA_W-1:0] addr;
    } desc_hdr_t;

    function automatic logic [LA_W-1:0] la_mask(input logic [DW-1:0] a);
        return a[LA_W-1:0];
    endfunction

    function automatic logic [WA_W-1:0] to_word(input logic [LA_W-1:0] a);
        return a[LA_W-1:2];
    endfunction

endpackage

// File: rtl/cmdlist_decode.sv
module cmdlist_decode
    import cmdlist_pkg::*;
#(
    parameter logic [3:0] TIC_CODE = 4'h8
) (
    input  logic [DW-1:0] word1,
    output desc_hdr_t     hdr
);
    always_comb begin
        hdr.code   = word1[27:24];
        hdr.is_tic = (word1[27:24] == TIC_CODE);
        hdr.addr   = la_mask(word1);
    end
endmodule

// File: rtl/cmdlist_range.sv
module cmdlist_range
    import cmdlist_pkg::*;
#(
    parameter int unsigned MEM_BYTES = 4096,
    parameter int unsigned NCHK      = 3
) (
    input  logic [NCHK-1:0][LA_W-1:0] addr,
    output logic [NCHK-1:0]           bad
);
    localparam logic [LA_W:0] LIMIT = (LA_W+1)'(MEM_BYTES);

    for (genvar g = 0; g < NCHK; g++) begin : g_chk
        assign bad[g] = ({1'b0, addr[g]} >= LIMIT);
    end
endmodule

// File: rtl/cmdlist_fetch.sv
module cmdlist_fetch
    import cmdlist_pkg::*;
#(
    parameter int unsigned MEM_BYTES = 4096,
    parameter logic [3:0]  TIC_CODE  = 4'h8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [31:0]     list_addr,
    input  logic            next_req,
    output logic            mem_rd_en,
    output logic [21:0]     mem_rd_addr,
    input  logic [31:0]     mem_rd_data,
    output logic            busy,
    output logic            cmd_valid,
    output logic [3:0]      cmd_code,
    output logic [23:0]     data_addr,
    output logic [31:0]     desc_w2,
    output logic            prog_check,
    output logic            chan_end,
    output logic            irq_pend
);
    localparam int unsigned MEM_WORDS = MEM_BYTES / 4;
    localparam int unsigned IDX_LIST  = 0;
    localparam int unsigned IDX_W2    = 1;
    localparam int unsigned IDX_DATA  = 2;

    fetch_st_e       st_q;
    logic [LA_W-1:0] caw_q;
    logic            tic_ok_q;
    logic            live_q;
    logic [3:0]      cmd_q;
    logic [LA_W-1:0] daddr_q;
    logic [DW-1:0]   w2_q;
    logic            valid_q;
    logic            pc_q, ce_q, irq_q;

    desc_hdr_t           hdr;
    logic [2:0][LA_W-1:0] chk_addr;
    logic [2:0]           chk_bad;
    logic [LA_W-1:0]      w2_addr;

    cmdlist_decode #(.TIC_CODE(TIC_CODE)) i_decode (
        .word1 (mem_rd_data),
        .hdr   (hdr)
    );

    assign w2_addr = caw_q + LA_W'(4);

    always_comb begin
        chk_addr[IDX_LIST] = caw_q;
        chk_addr[IDX_W2]   = w2_addr;
        chk_addr[IDX_DATA] = hdr.addr;
    end

    cmdlist_range #(.MEM_BYTES(MEM_BYTES), .NCHK(3)) i_range (
        .addr (chk_addr),
        .bad  (chk_bad)
    );

    always_comb begin
        mem_rd_en   = ((st_q == ST_RD1) && !chk_bad[IDX_LIST]) ||
                      ((st_q == ST_RD2) && !chk_bad[IDX_W2]);
        mem_rd_addr = (st_q == ST_RD2) ? to_word(w2_addr) : to_word(caw_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            caw_q    <= '0;
            tic_ok_q <= 1'b0;
            live_q   <= 1'b0;
            cmd_q    <= '0;
            daddr_q  <= '0;
            w2_q     <= '0;
            valid_q  <= 1'b0;
            pc_q     <= 1'b0;
            ce_q     <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        caw_q    <= la_mask(list_addr);
                        tic_ok_q <= 1'b0;
                        live_q   <= 1'b0;
                        pc_q     <= 1'b0;
                        ce_q     <= 1'b0;
                        irq_q    <= 1'b0;
                        st_q     <= ST_RD1;
                    end else if (next_req && live_q) begin
                        caw_q    <= caw_q + LA_W'(8);
                        tic_ok_q <= 1'b1;
                        st_q     <= ST_RD1;
                    end
                end
                ST_RD1: begin
                    if (chk_bad[IDX_LIST]) begin
                        pc_q   <= 1'b1;
                        ce_q   <= 1'b1;
                        irq_q  <= 1'b1;
                        live_q <= 1'b0;
                        st_q   <= ST_IDLE;
                    end else begin
                        st_q <= ST_W1;
                    end
                end
                ST_W1: begin
                    if (hdr.is_tic) begin
                        if (tic_ok_q) begin
                            caw_q    <= hdr.addr;
                            tic_ok_q <= 1'b0;
                            st_q     <= ST_RD1;
                        end else begin
                            pc_q   <= 1'b1;
                            ce_q   <= 1'b1;
                            irq_q  <= 1'b1;
                            live_q <= 1'b0;
                            st_q   <= ST_IDLE;
                        end
                    end else if (chk_bad[IDX_DATA]) begin
                        pc_q   <= 1'b1;
                        ce_q   <= 1'b1;
                        irq_q  <= 1'b1;
                        live_q <= 1'b0;
                        st_q   <= ST_IDLE;
                    end else begin
                        cmd_q   <= hdr.code;
                        daddr_q <= hdr.addr;
                        st_q    <= ST_RD2;
                    end
                end
                ST_RD2: begin
                    if (chk_bad[IDX_W2]) begin
                        pc_q   <= 1'b1;
                        ce_q   <= 1'b1;
                        irq_q  <= 1'b1;
                        live_q <= 1'b0;
                        st_q   <= ST_IDLE;
                    end else begin
                        st_q <= ST_W2;
                    end
                end
                ST_W2: begin
                    w2_q     <= mem_rd_data;
                    valid_q  <= 1'b1;
                    tic_ok_q <= 1'b1;
                    live_q   <= 1'b1;
                    st_q     <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (st_q != ST_IDLE);
    assign cmd_valid  = valid_q;
    assign cmd_code   = cmd_q;
    assign data_addr  = daddr_q;
    assign desc_w2    = w2_q;
    assign prog_check = pc_q;
    assign chan_end   = ce_q;
    assign irq_pend   = irq_q;

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy) else $error("busy missing after start"); // R9
    AST_VALID_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid) else $error("cmd_valid longer than one cycle"); // R9
    AST_VALID_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !busy) else $error("cmd_valid while busy"); // R9
    AST_ERR_TRIPLE: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_check) |-> (chan_end && irq_pend)) else $error("error flags split"); // R8
    AST_NO_VALID_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !prog_check) else $error("cmd_valid with program check"); // R8
    AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (int'(mem_rd_addr) < MEM_WORDS)) else $error("read beyond memory"); // R3
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (prog_check && !start) |=> prog_check) else $error("status lost without start"); // R11
endmodule

// File: tb/test_cmdlist_fetch.sv
`timescale 1ns/1ps
module test_cmdlist_fetch;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] list_addr = '0;
    logic        next_req = 1'b0;
    logic        mem_rd_en;
    logic [21:0] mem_rd_addr;
    logic [31:0] mem_rd_data;
    logic        busy, cmd_valid, prog_check, chan_end, irq_pend;
    logic [3:0]  cmd_code;
    logic [23:0] data_addr;
    logic [31:0] desc_w2;

    always #4 clk = ~clk;

    cmdlist_fetch i_cmdlist_fetch (
        .clk(clk), .rst(rst), .start(start), .list_addr(list_addr),
        .next_req(next_req), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .busy(busy), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .data_addr(data_addr), .desc_w2(desc_w2),
        .prog_check(prog_check), .chan_end(chan_end), .irq_pend(irq_pend)
    );

    logic [31:0] mem [0:1023];
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:0]];

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0;
    int nfail = 0;

    typedef struct {
        int          due;
        bit          err;
        logic [3:0]  cmd;
        logic [23:0] da;
        logic [31:0] w2;
        string       req;
    } exp_t;
    exp_t q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: compares at the cycle busy falls
    bit busy_d = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (busy_d && !busy) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected completion", 32'(cyc), 32'hFFFF_FFFF);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cyc == e.due, e.req, "completion cycle", 32'(cyc), 32'(e.due));
                    chk(cmd_valid == !e.err, e.req, "cmd_valid", 32'(cmd_valid), 32'(!e.err));
                    chk(prog_check == e.err, e.req, "prog_check", 32'(prog_check), 32'(e.err));
                    chk(chan_end == e.err, e.req, "chan_end", 32'(chan_end), 32'(e.err));
                    chk(irq_pend == e.err, e.req, "irq_pend", 32'(irq_pend), 32'(e.err));
                    if (!e.err) begin
                        chk(cmd_code == e.cmd, e.req, "cmd_code", 32'(cmd_code), 32'(e.cmd));
                        chk(data_addr == e.da, e.req, "data_addr", 32'(data_addr), 32'(e.da));
                        chk(desc_w2 == e.w2, e.req, "desc_w2", desc_w2, e.w2);
                    end
                end
            end
            busy_d = busy;
        end
    end

    task automatic launch(input logic [31:0] a, input bit nxt, input bit err,
                          input logic [3:0] cmd, input logic [23:0] da,
                          input logic [31:0] w2, input int lat, input string req);
        exp_t e;
        @(negedge clk);
        e.due = cyc + 1 + lat; e.err = err; e.cmd = cmd; e.da = da; e.w2 = w2; e.req = req;
        q.push_back(e);
        if (nxt) next_req = 1'b1;
        else begin list_addr = a; start = 1'b1; end
        @(negedge clk);
        start = 1'b0; next_req = 1'b0;
    endtask

    task automatic settle;
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #200000;
        nfail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        mem['h100>>2] = 32'h0300_0400; mem['h104>>2] = 32'h1234_5678;
        mem['h108>>2] = 32'h0800_0200;
        mem['h200>>2] = 32'hF500_0800; mem['h204>>2] = 32'hCAFE_0001;
        mem['h208>>2] = 32'h0800_0300;
        mem['h300>>2] = 32'h0800_0100;
        mem['h400>>2] = 32'h0200_3000;
        mem['hFFC>>2] = 32'h0100_0010;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !cmd_valid, "R1", "busy/valid after reset", {busy, cmd_valid}, 0);
        chk(!prog_check && !chan_end && !irq_pend, "R1", "status after reset",
            {prog_check, chan_end, irq_pend}, 0);

        // R2 R4: upper list bits masked; plain descriptor, 4 cycles
        launch(32'hAB00_0100, 1'b0, 1'b0, 4'h3, 24'h400, 32'h1234_5678, 4, "R4");
        // R3: first read in the cycle after start
        chk(mem_rd_en && mem_rd_addr == 22'h40, "R3", "first read word addr",
            {mem_rd_en, 9'h0, mem_rd_addr}, {1'b1, 9'h0, 22'h40});
        settle();

        // R10 R5: next descriptor at +8 is a TIC to 0x200, code from [27:24]
        launch(0, 1'b1, 1'b0, 4'h5, 24'h800, 32'hCAFE_0001, 6, "R10");
        settle();

        // R7: next at 0x208 is TIC to 0x300, which is another TIC
        launch(0, 1'b1, 1'b1, 0, 0, 0, 4, "R7");
        settle();
        // R11 flags persist
        repeat (5) @(negedge clk);
        chk(prog_check && chan_end && irq_pend, "R11", "flags held",
            {prog_check, chan_end, irq_pend}, 3'b111);
        // R12 next_req after error ignored
        next_req = 1'b1; @(negedge clk); next_req = 1'b0; @(negedge clk);
        chk(!busy && prog_check, "R12", "next after error", {busy, prog_check}, 2'b01);

        // R6: TIC first in chain
        launch(32'h0000_0300, 1'b0, 1'b1, 0, 0, 0, 2, "R6");
        settle();

        // R8: list address out of range
        launch(32'h0000_2000, 1'b0, 1'b1, 0, 0, 0, 1, "R8");
        settle();
        // R8: data address out of range
        launch(32'h0000_0400, 1'b0, 1'b1, 0, 0, 0, 2, "R8");
        settle();
        // R8: word 2 address out of range
        launch(32'h0000_0FFC, 1'b0, 1'b1, 0, 0, 0, 3, "R8");
        settle();

        // R11 start clears flags; R5 TIC from chain not first (start at 0x100 then TIC?) plain run
        launch(32'h0000_0100, 1'b0, 1'b0, 4'h3, 24'h400, 32'h1234_5678, 4, "R11");
        // R12: second start while busy ignored
        start = 1'b1; list_addr = 32'h0000_0200;
        @(negedge clk); start = 1'b0;
        settle();

        // R2: list address with upper bits pointing at 0x200
        launch(32'hFF00_0200, 1'b0, 1'b0, 4'h5, 24'h800, 32'hCAFE_0001, 4, "R2");
        settle();

        chk(q.size() == 0, "R9", "pending expectations", 32'(q.size()), 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule